// File: doc/BRIEF.md
# RTC Interrupt Control Register

This block is the control register of a real-time clock, together with the interrupt logic it governs. It runs from the 32.768 kHz timekeeping clock. A plain write/read port stands in for the host bus. The register holds three things: a two-bit selector for the temperature-compensation interval, three interrupt enables (update, fixed-cycle timer and alarm), and a stop/reset control bit. Two bits of the register cannot be written.

Two event flags come in from the timekeeping logic: the once-per-update flag and the fixed-cycle timer flag. A rising edge on either flag, when its enable is set, makes that source request the interrupt output. Each request ends by itself after a fixed hold of about 7.8 ms, which is 256 reference cycles by default. It also ends at once when software writes 0 to that source's enable. The interrupt pin is open-drain and active low. It is modelled as a "drive low" enable that is high while any source is requesting.

In parallel, a compensation timer emits a one-cycle pulse at the end of every interval that the selector picks. The alarm enable is only stored here for the alarm comparator. The register port and the flags are plain control signals, so there is no back-pressure: every write takes effect at the clock edge where `wr_en` is high.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 8'h40: selector bits [7:6] = 01, and the enables (bits 5, 4, 3) and the control bit (bit 0) are all 0. `int_drive_low` and `comp_tick` are low.
- R2: A write stores bits 7, 6 (selector), 5 (update enable), 4 (timer enable), 3 (alarm enable) and 0 (control bit), which then read back unchanged. Bits 2 and 1 ignore writes and always read 0.
- R3: The selector sets the compensation interval in units of HALF_SEC_CYCLES: 00 gives 1 unit, 01 gives 4, 10 gives 20 and 11 gives 60. `comp_tick` is high for exactly one cycle, in the cycle after the interval's last clock edge.
- R4: Any register write restarts the compensation interval count from zero at that write's clock edge.
- R5: A 0-to-1 change of `uf_flag`, sampled at a clock edge while the update enable is 1, drives `int_drive_low` high from the next cycle. With the enable at 0, or with the flag held high, no request is made.
- R6: A 0-to-1 change of `tf_flag` acts the same way, gated by the timer enable.
- R7: A source's request lasts exactly RELEASE_CYCLES cycles and then ends by itself.
- R8: A new qualifying edge on a source whose request is still active restarts that source's RELEASE_CYCLES hold.
- R9: Writing 0 to a source's enable ends that source's request at the same write edge. The other source is not affected.
- R10: `int_drive_low` is high while at least one source is requesting, and low only when neither is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register value |
| uf_flag | input | 1 | Time-update event flag |
| tf_flag | input | 1 | Fixed-cycle timer event flag |
| int_drive_low | output | 1 | High = pull the interrupt pin low; low = released |
| comp_tick | output | 1 | One-cycle compensation trigger |

## Verification
The hardest state to reach is two sources overlapping: one is still within its hold while the other is cancelled by a write, or a source is retriggered near the end of its hold. Directed sequences build these overlaps deliberately: a timer request, then an update request, then clearing only the update enable, then the timer enable. A long random phase follows. In that phase, sparse writes with random enables and selector values race against randomly toggling flags, and every cycle is compared with a bench reference model. The bench shortens the half-second unit so that all four compensation intervals fit in the run.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

  typedef enum logic [1:0] {
    CMP_UNIT1  = 2'b00,
    CMP_UNIT4  = 2'b01,
    CMP_UNIT20 = 2'b10,
    CMP_UNIT60 = 2'b11
  } cmp_sel_e;

  typedef struct packed {
    cmp_sel_e csel;
    logic     upd_en;
    logic     tmr_en;
    logic     alm_en;
    logic     run_ctl;
  } ctrl_fields_t;

  localparam int unsigned BIT_CSEL_HI = 7;
  localparam int unsigned BIT_CSEL_LO = 6;
  localparam int unsigned BIT_UPD_EN  = 5;
  localparam int unsigned BIT_TMR_EN  = 4;
  localparam int unsigned BIT_ALM_EN  = 3;
  localparam int unsigned BIT_RUN_CTL = 0;

  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_UPD = 0;
  localparam int unsigned SRC_TMR = 1;

  localparam int unsigned MAX_UNITS = 60;

  function automatic int unsigned interval_units(input cmp_sel_e s);
    case (s)
      CMP_UNIT1:  return 1;
      CMP_UNIT4:  return 4;
      CMP_UNIT20: return 20;
      default:    return 60;
    endcase
  endfunction

endpackage

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_irq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [7:0]   wr_data,
  output ctrl_fields_t fields,
  output logic [7:0]   rd_data,
  output logic [NUM_SRC-1:0] src_en_eff,
  output logic [NUM_SRC-1:0] src_cancel
);

  localparam ctrl_fields_t FIELDS_RST = '{
    csel:    CMP_UNIT4,
    upd_en:  1'b0,
    tmr_en:  1'b0,
    alm_en:  1'b0,
    run_ctl: 1'b0
  };

  ctrl_fields_t fields_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= FIELDS_RST;
    end else if (wr_en) begin
      fields_q.csel    <= cmp_sel_e'(wr_data[BIT_CSEL_HI:BIT_CSEL_LO]);
      fields_q.upd_en  <= wr_data[BIT_UPD_EN];
      fields_q.tmr_en  <= wr_data[BIT_TMR_EN];
      fields_q.alm_en  <= wr_data[BIT_ALM_EN];
      fields_q.run_ctl <= wr_data[BIT_RUN_CTL];
    end
  end

  assign fields = fields_q;

  always_comb begin
    rd_data = 8'h00;
    rd_data[BIT_CSEL_HI:BIT_CSEL_LO] = fields_q.csel;
    rd_data[BIT_UPD_EN]  = fields_q.upd_en;
    rd_data[BIT_TMR_EN]  = fields_q.tmr_en;
    rd_data[BIT_ALM_EN]  = fields_q.alm_en;
    rd_data[BIT_RUN_CTL] = fields_q.run_ctl;
  end

  // The enable that governs an event at this edge is the one being written,
  // if a write is in progress; the same write can cancel an active request.
  always_comb begin
    src_en_eff[SRC_UPD] = wr_en ? wr_data[BIT_UPD_EN] : fields_q.upd_en;
    src_en_eff[SRC_TMR] = wr_en ? wr_data[BIT_TMR_EN] : fields_q.tmr_en;
    src_cancel[SRC_UPD] = wr_en & ~wr_data[BIT_UPD_EN];
    src_cancel[SRC_TMR] = wr_en & ~wr_data[BIT_TMR_EN];
  end

  AST_CSEL_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (fields_q.csel == $past(wr_data[BIT_CSEL_HI:BIT_CSEL_LO]))); // R2

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data)); // R2

endmodule

// File: rtl/rtc_irq_source.sv
module rtc_irq_source #(
  parameter int unsigned RELEASE_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag,
  input  logic en_eff,
  input  logic cancel,
  output logic active
);

  localparam int unsigned CW = (RELEASE_CYCLES > 2) ? $clog2(RELEASE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(RELEASE_CYCLES - 1);

  logic          flag_q;
  logic          active_q;
  logic [CW-1:0] hold_cnt;
  logic          rise;
  logic          qualify;

  assign rise    = flag & ~flag_q;
  assign qualify = rise & en_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      hold_cnt <= '0;
    end else if (qualify) begin
      active_q <= 1'b1;
      hold_cnt <= '0;
    end else if (cancel) begin
      active_q <= 1'b0;
      hold_cnt <= '0;
    end else if (active_q) begin
      if (hold_cnt == LAST) begin
        active_q <= 1'b0;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

  assign active = active_q;

  AST_EVENT_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    qualify |=> active_q); // R5

  AST_CANCEL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && !qualify) |=> !active_q); // R9

  AST_HOLD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && hold_cnt == LAST && !qualify) |=> !active_q); // R7

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !qualify) |=> !active_q); // R5

  AST_RETRIGGER_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && qualify) |=> (active_q && hold_cnt == '0)); // R8

endmodule

// File: rtl/rtc_comp_timer.sv
module rtc_comp_timer
  import rtc_irq_pkg::*;
#(
  parameter int unsigned HALF_SEC_CYCLES = 16384
) (
  input  logic     clk,
  input  logic     rst_n,
  input  cmp_sel_e csel,
  input  logic     restart,
  output logic     tick
);

  localparam int unsigned MAX_LEN = HALF_SEC_CYCLES * MAX_UNITS;
  localparam int unsigned CW      = $clog2(MAX_LEN);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          tick_q;

  assign limit = CW'(HALF_SEC_CYCLES * interval_units(csel) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      tick_q <= 1'b0;
    end else if (restart) begin
      cnt    <= '0;
      tick_q <= 1'b0;
    end else if (cnt >= limit) begin
      cnt    <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q); // R3

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0 && !tick_q)); // R4

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (cnt <= limit)); // R3

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int unsigned HALF_SEC_CYCLES = 16384,
  parameter int unsigned RELEASE_CYCLES  = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       uf_flag,
  input  logic       tf_flag,
  output logic       int_drive_low,
  output logic       comp_tick
);

  ctrl_fields_t       fields;
  logic [NUM_SRC-1:0] src_en_eff;
  logic [NUM_SRC-1:0] src_cancel;
  logic [NUM_SRC-1:0] src_flag;
  logic [NUM_SRC-1:0] src_active;

  assign src_flag[SRC_UPD] = uf_flag;
  assign src_flag[SRC_TMR] = tf_flag;

  rtc_ctrl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .fields     (fields),
    .rd_data    (rd_data),
    .src_en_eff (src_en_eff),
    .src_cancel (src_cancel)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    rtc_irq_source #(
      .RELEASE_CYCLES (RELEASE_CYCLES)
    ) u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag   (src_flag[g]),
      .en_eff (src_en_eff[g]),
      .cancel (src_cancel[g]),
      .active (src_active[g])
    );
  end

  rtc_comp_timer #(
    .HALF_SEC_CYCLES (HALF_SEC_CYCLES)
  ) u_comp (
    .clk     (clk),
    .rst_n   (rst_n),
    .csel    (fields.csel),
    .restart (wr_en),
    .tick    (comp_tick)
  );

  assign int_drive_low = |src_active;

  AST_PIN_FOLLOWS_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
    (src_active[SRC_UPD] || src_active[SRC_TMR]) |-> int_drive_low); // R10

endmodule

// File: tb/test_rtc_irq_ctrl.sv
module test_rtc_irq_ctrl;

  localparam int unsigned HALF = 32;
  localparam int unsigned REL  = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       uf_flag = 1'b0;
  logic       tf_flag = 1'b0;
  logic       int_drive_low;
  logic       comp_tick;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_cnt = 0;

  always #5 clk = ~clk;

  rtc_irq_ctrl #(.HALF_SEC_CYCLES(HALF), .RELEASE_CYCLES(REL)) i_rtc_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .uf_flag(uf_flag), .tf_flag(tf_flag), .int_drive_low(int_drive_low), .comp_tick(comp_tick)
  );

  // Reference model, built from the requirements
  logic [1:0] m_csel;
  logic m_uie, m_tie, m_aie, m_ctl, m_ufq, m_tfq, m_ua, m_ta, m_tick;
  int   m_uc, m_tc, m_cc;

  function automatic int comp_len(input logic [1:0] s);
    case (s)
      2'b00: return HALF;
      2'b01: return HALF * 4;
      2'b10: return HALF * 20;
      default: return HALF * 60;
    endcase
  endfunction

  function automatic logic [7:0] model_rd();
    return {m_csel, m_uie, m_tie, m_aie, 2'b00, m_ctl};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_csel = 2'b01; m_uie = 0; m_tie = 0; m_aie = 0; m_ctl = 0;
      m_ufq = 0; m_tfq = 0; m_ua = 0; m_ta = 0; m_uc = 0; m_tc = 0;
      m_cc = 0; m_tick = 0;
    end else begin
      logic ue, te;
      ue = wr_en ? wr_data[5] : m_uie;
      te = wr_en ? wr_data[4] : m_tie;
      if (uf_flag && !m_ufq && ue) begin m_ua = 1; m_uc = 0; end
      else if (wr_en && !wr_data[5]) begin m_ua = 0; m_uc = 0; end
      else if (m_ua) begin
        if (m_uc == REL - 1) begin m_ua = 0; m_uc = 0; end else m_uc++;
      end
      if (tf_flag && !m_tfq && te) begin m_ta = 1; m_tc = 0; end
      else if (wr_en && !wr_data[4]) begin m_ta = 0; m_tc = 0; end
      else if (m_ta) begin
        if (m_tc == REL - 1) begin m_ta = 0; m_tc = 0; end else m_tc++;
      end
      if (wr_en) begin m_cc = 0; m_tick = 0; end
      else if (m_cc >= comp_len(m_csel) - 1) begin m_cc = 0; m_tick = 1; end
      else begin m_cc++; m_tick = 0; end
      if (wr_en) begin
        m_csel = wr_data[7:6]; m_uie = wr_data[5]; m_tie = wr_data[4];
        m_aie = wr_data[3]; m_ctl = wr_data[0];
      end
      m_ufq = uf_flag; m_tfq = tf_flag;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Advance one clock, then compare every output at the falling edge
  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    cyc_cnt++;
    chk({tag, " int"}, {31'd0, int_drive_low}, {31'd0, (m_ua | m_ta)});
    chk({tag, " tick"}, {31'd0, comp_tick}, {31'd0, m_tick});
    chk({tag, " rd"}, {24'd0, rd_data}, {24'd0, model_rd()});
  endtask

  task automatic wr(input logic [7:0] v, input string tag);
    wr_en = 1'b1; wr_data = v;
    step(tag);
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 rd", {24'd0, rd_data}, 32'h40);
    chk("R1 int", {31'd0, int_drive_low}, 32'd0);
    chk("R1 tick", {31'd0, comp_tick}, 32'd0);
    rst_n = 1'b1;
    step("R1");

    // R2: write-protected bits read 0
    wr(8'hFF, "R2");
    chk("R2 rd after FF", {24'd0, rd_data}, 32'hF9);
    wr(8'h06, "R2");
    chk("R2 protected", {24'd0, rd_data}, 32'h00);

    // R3/R4: shortest interval counted from the write edge
    wr(8'h00, "R4");
    for (int i = 1; i < int'(HALF); i++) begin
      step("R3");
      chk("R3 no early tick", {31'd0, comp_tick}, 32'd0);
    end
    step("R3");
    chk("R3 tick at end", {31'd0, comp_tick}, 32'd1);
    step("R3");
    chk("R3 one cycle", {31'd0, comp_tick}, 32'd0);
    for (int s = 1; s < 4; s++) begin
      wr({s[1:0], 6'h00}, "R4");
      for (int i = 1; i <= comp_len(s[1:0]) + 2; i++) step("R3");
    end

    // R5: disabled update enable ignores the edge
    wr(8'h00, "R5");
    uf_flag = 1'b1; step("R5");
    chk("R5 disabled", {31'd0, int_drive_low}, 32'd0);
    uf_flag = 1'b0; step("R5");
    wr(8'h20, "R5");
    uf_flag = 1'b1; step("R5");
    chk("R5 asserted", {31'd0, int_drive_low}, 32'd1);
    // R7: held flag gives no new event; release after REL cycles
    for (int i = 1; i < int'(REL); i++) step("R7");
    chk("R7 still low", {31'd0, int_drive_low}, 32'd1);
    step("R7");
    chk("R7 released", {31'd0, int_drive_low}, 32'd0);
    uf_flag = 1'b0; step("R5");

    // R8: retrigger restarts the hold
    uf_flag = 1'b1; step("R8");
    uf_flag = 1'b0; repeat (10) step("R8");
    uf_flag = 1'b1; step("R8");
    for (int i = 1; i < int'(REL); i++) step("R8");
    chk("R8 extended", {31'd0, int_drive_low}, 32'd1);
    step("R8");
    chk("R8 ends", {31'd0, int_drive_low}, 32'd0);
    uf_flag = 1'b0; step("R8");

    // R6/R9/R10: overlap, then cancel one source, then the other
    wr(8'h30, "R6");
    tf_flag = 1'b1; step("R6");
    chk("R6 timer asserted", {31'd0, int_drive_low}, 32'd1);
    uf_flag = 1'b1; step("R10");
    wr(8'h10, "R9");
    chk("R10 timer keeps pin", {31'd0, int_drive_low}, 32'd1);
    wr(8'h00, "R9");
    chk("R9 cancelled", {31'd0, int_drive_low}, 32'd0);
    uf_flag = 1'b0; tf_flag = 1'b0; step("R9");

    // Random phase against the model
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 59) == 0) begin
        wr_en = 1'b1;
        wr_data = $urandom_range(0, 255);
        if ($urandom_range(0, 1) == 1) wr_data[7] = 1'b0;
      end
      if ($urandom_range(0, 15) == 0) uf_flag = ~uf_flag;
      if ($urandom_range(0, 15) == 0) tf_flag = ~tf_flag;
      step("R10 random");
      wr_en = 1'b0;
    end
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired R1 actual=hung expected=done");
    summary();
  end

endmodule